// File: doc/BRIEF.md
# Byte Register Bus Slave

This block is the host-facing side of a link datapath. A host on a simple synchronous system bus uses it to reach a small bank of byte-wide control and status registers. The control registers set the two parity-checker enables and four FIFO watermark levels, and the block drives these settings straight out to the datapath. The status register keeps every error pulse the datapath reports (FIFO overflow and underflow on both the data and the control FIFO, horizontal and vertical parity). Each error stays latched until the host clears it by writing a 1 to its bit.

A bus cycle starts when the active-low enable is seen low. The block samples the address and write/read select on that edge, carries out any write on the same edge, and pulses the acknowledge for one clock. The read bus is 32 bits wide, but every register is a single byte, so a read drives the same byte onto all four lanes. The read bus is released to high impedance unless a read cycle addresses an implemented register. A separate output-enable tells the surrounding bus fabric when the slave is driving. Cycles to unimplemented addresses still complete with an acknowledge.

Top module: `byte_reg_slave`

## Requirements
- R1: After the active-low reset, every register reads 0x00, the acknowledge is low, the read bus is not driven, and the enable and watermark outputs are 0.
- R2: The acknowledge rises one clock after the enable is first sampled low and stays high for exactly one clock. No further acknowledge occurs until the enable has been sampled high and then low again.
- R3: A write cycle (select high) stores the write byte on the accepting edge. The offsets from the base address are: 0 enables, 1 data-FIFO high mark, 2 data-FIFO low mark, 3 control-FIFO high mark, 4 control-FIFO low mark, 5 error flags. The watermark output carries mark k in bits 8k+7:8k.
- R4: While the enable is low, the select is low and the address hits an implemented register, the output-enable is high and all four byte lanes of the read bus carry that register's byte.
- R5: The output-enable is low, and the read bus is high impedance, whenever the enable is high, the select is high, or the address is not one of offsets 0 to 5.
- R6: Error flag bit b is set by a one-cycle pulse on error input b and stays set until it is cleared. Bit 0 is data-FIFO overflow, bit 1 data-FIFO underflow, bit 2 control-FIFO overflow, bit 3 control-FIFO underflow, bit 4 horizontal parity and bit 5 vertical parity. Bits 7:6 read 0.
- R7: Writing to offset 5 clears exactly those flags whose write-data bit is 1. The other flags keep their value.
- R8: When an error pulse and a clearing write to the same bit fall on the same edge, the flag ends up set.
- R9: A write to an unimplemented address is acknowledged and changes no register.
- R10: Enable-register bit 0 drives the horizontal-parity enable and bit 1 drives the vertical-parity enable. Bits 7:2 of that register are not stored and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_n | input | 1 | Bus-cycle enable, active low |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 18 | Register address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 32 | Read data, byte copied to all lanes, high impedance when not driven |
| bus_rdata_oe | output | 1 | High while the slave drives bus_rdata |
| bus_ack | output | 1 | One-clock cycle acknowledge |
| err_pulse | input | 6 | Error pulses from the datapath |
| chk_en | output | 2 | Parity-check enables (bit 0 horizontal, bit 1 vertical) |
| wm_levels | output | 32 | Four watermark bytes, mark k in bits 8k+7:8k |

## Verification
The assertions watch the handshake on every clock: an acknowledge never lasts two cycles and always follows a low enable. They also check that the read bus is released outside read cycles, that a latched error flag only drops under a clearing write, that a pulse always leaves its flag set, and that no register moves without a decoded write. Stored values can only be shown by the bench's scenarios, which compare the design clock by clock against a behavioural model. These scenarios cover lane replication, write-1-to-clear masks, a pulse meeting a clear on the same edge, the unstored enable bits, and unimplemented addresses at both ends of the address space.

// File: rtl/brs_pkg.sv
package brs_pkg;
   // register offsets from the base address
   localparam int OFS_CTRL = 0;
   localparam int OFS_WM0  = 1;

   // enable bits
   localparam int CTL_HPAR = 0;
   localparam int CTL_VPAR = 1;

   // error flag bit positions
   typedef enum int {
      ERRB_DOVF = 0,
      ERRB_DUNF = 1,
      ERRB_COVF = 2,
      ERRB_CUNF = 3,
      ERRB_HPAR = 4,
      ERRB_VPAR = 5
   } err_bit_e;

   localparam int NUM_ERR_BITS = 6;
endpackage

// File: rtl/brs_handshake.sv
module brs_handshake (
   input  logic clk,
   input  logic rst_n,
   input  logic en_n,
   output logic accept,
   output logic ack
);
   logic busy_q;

   // a cycle is taken once per low phase of the enable
   assign accept = !en_n && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ack    <= 1'b0;
      end else begin
         busy_q <= !en_n;
         ack    <= accept;
      end
   end

   a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   a_r2_ack_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(!en_n));
endmodule

// File: rtl/brs_ctrl_regs.sv
module brs_ctrl_regs #(
   parameter int DATA_W = 8,
   parameter int CTRL_W = 2,
   parameter int NUM_WM = 4,
   parameter int SEL_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         wr_sel,
   input  logic [DATA_W-1:0]        wdata,
   output logic [CTRL_W-1:0]        ctrl_q,
   output logic [NUM_WM*DATA_W-1:0] wm_q
);
   import brs_pkg::*;

   if (CTRL_W > DATA_W) begin : g_bad_ctrl
      $error("brs_ctrl_regs: CTRL_W exceeds DATA_W");
   end
   if ((OFS_WM0 + NUM_WM) >= (1 << SEL_W)) begin : g_bad_sel
      $error("brs_ctrl_regs: SEL_W too narrow for register count");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && wr_sel == SEL_W'(OFS_CTRL)) begin
         ctrl_q <= wdata[CTRL_W-1:0];
      end
   end

   for (genvar k = 0; k < NUM_WM; k++) begin : g_wm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wm_q[k*DATA_W +: DATA_W] <= '0;
         end else if (wr_en && wr_sel == SEL_W'(OFS_WM0 + k)) begin
            wm_q[k*DATA_W +: DATA_W] <= wdata;
         end
      end
   end

   a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(ctrl_q) && $stable(wm_q)));
endmodule

// File: rtl/brs_err_flags.sv
module brs_err_flags #(
   parameter int ERR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_W-1:0] set_in,
   input  logic [ERR_W-1:0] clr_in,
   output logic [ERR_W-1:0] flags
);
   for (genvar b = 0; b < ERR_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[b] <= 1'b0;
         end else if (set_in[b]) begin
            flags[b] <= 1'b1;   // a new pulse outranks a clear
         end else if (clr_in[b]) begin
            flags[b] <= 1'b0;
         end
      end

      a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[b] && !clr_in[b]) |=> flags[b]);
      a_r8_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_in[b] |=> flags[b]);
   end
endmodule

// File: rtl/byte_reg_slave.sv
module byte_reg_slave #(
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 8,
   parameter int BUS_W     = 32,
   parameter int BASE_ADDR = 0,
   parameter int CTRL_W    = 2,
   parameter int NUM_WM    = 4,
   parameter int ERR_W     = brs_pkg::NUM_ERR_BITS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_en_n,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output wire  [BUS_W-1:0]         bus_rdata,
   output logic                     bus_rdata_oe,
   output logic                     bus_ack,
   input  logic [ERR_W-1:0]         err_pulse,
   output logic [CTRL_W-1:0]        chk_en,
   output logic [NUM_WM*DATA_W-1:0] wm_levels
);
   import brs_pkg::*;

   localparam int OFS_ERR = OFS_WM0 + NUM_WM;
   localparam int NREG    = OFS_ERR + 1;
   localparam int SEL_W   = $clog2(NREG);
   localparam int LANES   = BUS_W / DATA_W;

   if (BUS_W % DATA_W != 0) begin : g_bad_bus
      $error("byte_reg_slave: BUS_W must be a multiple of DATA_W");
   end
   if (ERR_W > DATA_W) begin : g_bad_err
      $error("byte_reg_slave: ERR_W exceeds DATA_W");
   end
   if (BASE_ADDR + NREG > (1 << ADDR_W)) begin : g_bad_base
      $error("byte_reg_slave: register window leaves the address space");
   end

   // handshake
   logic accept;

   brs_handshake u_hs (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_n   (bus_en_n),
      .accept (accept),
      .ack    (bus_ack)
   );

   // address decode
   logic [ADDR_W-1:0] offset;
   logic              hit;
   logic [SEL_W-1:0]  sel;
   logic              wr_fire;

   assign offset  = bus_addr - ADDR_W'(BASE_ADDR);
   assign hit     = (bus_addr >= ADDR_W'(BASE_ADDR)) && (offset < ADDR_W'(NREG));
   assign sel     = offset[SEL_W-1:0];
   assign wr_fire = accept && bus_wr && hit;

   // control registers
   logic [CTRL_W-1:0]        ctrl_q;
   logic [NUM_WM*DATA_W-1:0] wm_q;

   brs_ctrl_regs #(
      .DATA_W (DATA_W),
      .CTRL_W (CTRL_W),
      .NUM_WM (NUM_WM),
      .SEL_W  (SEL_W)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_fire),
      .wr_sel (sel),
      .wdata  (bus_wdata),
      .ctrl_q (ctrl_q),
      .wm_q   (wm_q)
   );

   assign chk_en    = ctrl_q;
   assign wm_levels = wm_q;

   // sticky error flags, write 1 to clear
   logic [ERR_W-1:0] err_clr;
   logic [ERR_W-1:0] err_q;

   assign err_clr = (wr_fire && sel == SEL_W'(OFS_ERR)) ? bus_wdata[ERR_W-1:0] : '0;

   brs_err_flags #(
      .ERR_W (ERR_W)
   ) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_in (err_pulse),
      .clr_in (err_clr),
      .flags  (err_q)
   );

   // read path
   logic [DATA_W-1:0] rd_byte;

   always_comb begin
      rd_byte = '0;
      if (sel == SEL_W'(OFS_CTRL)) begin
         rd_byte[CTRL_W-1:0] = ctrl_q;
      end
      for (int k = 0; k < NUM_WM; k++) begin
         if (sel == SEL_W'(OFS_WM0 + k)) begin
            rd_byte = wm_q[k*DATA_W +: DATA_W];
         end
      end
      if (sel == SEL_W'(OFS_ERR)) begin
         rd_byte[ERR_W-1:0] = err_q;
      end
   end

   assign bus_rdata_oe = !bus_en_n && !bus_wr && hit;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign bus_rdata[ln*DATA_W +: DATA_W] = bus_rdata_oe ? rd_byte : {DATA_W{1'bz}};
   end

   a_r5_release_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en_n || bus_wr) |-> !bus_rdata_oe);
   a_r9_no_write_off_map: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> !wr_fire);
endmodule

// File: tb/tb_byte_reg_slave.sv
module tb_byte_reg_slave;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en_n = 1'b1;
   logic        bus_wr = 1'b0;
   logic [17:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   wire  [31:0] bus_rdata;
   logic        bus_rdata_oe;
   logic        bus_ack;
   logic [5:0]  err_pulse = '0;
   logic [1:0]  chk_en;
   logic [31:0] wm_levels;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   byte_reg_slave dut (
      .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rdata_oe(bus_rdata_oe), .bus_ack(bus_ack), .err_pulse(err_pulse),
      .chk_en(chk_en), .wm_levels(wm_levels)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_reg[6];
   bit m_busy = 1'b0;
   bit m_ack  = 1'b0;

   initial foreach (m_reg[i]) m_reg[i] = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_reg[i]) m_reg[i] = 0;
         m_busy = 1'b0;
         m_ack  = 1'b0;
      end else begin
         bit take;
         int e;
         take = !bus_en_n && !m_busy;
         e = m_reg[5];
         if (take && bus_wr && bus_addr < 6) begin
            if (bus_addr == 0) m_reg[0] = bus_wdata & 8'h03;
            else if (bus_addr == 5) e = e & ~int'(bus_wdata) & 8'h3F;
            else m_reg[bus_addr] = bus_wdata;
         end
         m_reg[5] = e | int'(err_pulse);
         m_ack  = take;
         m_busy = !bus_en_n;
      end
   end

   // clock-by-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit exp_oe;
         exp_oe = !bus_en_n && !bus_wr && (bus_addr < 6);
         check("R2 ack", {31'd0, bus_ack}, {31'd0, m_ack});
         check("R5 oe", {31'd0, bus_rdata_oe}, {31'd0, exp_oe});
         if (exp_oe && bus_rdata_oe)
            check("R4 lanes", bus_rdata, {4{m_reg[bus_addr][7:0]}});
         check("R10 chk_en", {30'd0, chk_en}, 32'(m_reg[0]));
         check("R3 wm_levels", wm_levels,
               {m_reg[4][7:0], m_reg[3][7:0], m_reg[2][7:0], m_reg[1][7:0]});
      end
   end

   // one bus cycle, enable held low for hold clocks
   task automatic cyc(input bit wr, input logic [17:0] a, input logic [7:0] d,
                      input int hold, input logic [5:0] pulse,
                      output logic [7:0] rb, output bit saw_oe, output int acks);
      rb = '0; saw_oe = 0; acks = 0;
      @(posedge clk); #1;
      bus_en_n = 1'b0; bus_wr = wr; bus_addr = a; bus_wdata = d; err_pulse = pulse;
      @(negedge clk);
      if (bus_rdata_oe) begin saw_oe = 1; rb = bus_rdata[7:0]; end
      acks += int'(bus_ack);
      @(posedge clk); #1;
      err_pulse = '0;
      for (int i = 1; i < hold; i++) begin
         @(negedge clk);
         if (bus_rdata_oe) begin saw_oe = 1; rb = bus_rdata[7:0]; end
         acks += int'(bus_ack);
      end
      @(posedge clk); #1;
      bus_en_n = 1'b1;
      @(negedge clk);
      acks += int'(bus_ack);
      @(posedge clk);
   endtask

   task automatic wr_reg(input logic [17:0] a, input logic [7:0] d);
      logic [7:0] rb; bit oe; int n;
      cyc(1'b1, a, d, 3, 6'h0, rb, oe, n);
   endtask

   task automatic rd_reg(input logic [17:0] a, output logic [7:0] rb);
      bit oe; int n;
      cyc(1'b0, a, 8'h00, 3, 6'h0, rb, oe, n);
   endtask

   initial begin
      logic [7:0] rb;
      bit oe;
      int n;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      check("R1 ack", {31'd0, bus_ack}, 32'd0);
      check("R1 chk_en", {30'd0, chk_en}, 32'd0);
      check("R1 wm", wm_levels, 32'd0);
      for (int a = 0; a < 6; a++) begin
         rd_reg(18'(a), rb);
         check("R1 reg", {24'd0, rb}, 32'd0);
      end

      // R3/R4: watermark writes and read back
      wr_reg(18'd1, 8'hA5); wr_reg(18'd2, 8'h3C);
      wr_reg(18'd3, 8'hFF); wr_reg(18'd4, 8'h81);
      check("R3 wm map", wm_levels, 32'h81FF3CA5);
      rd_reg(18'd2, rb);
      check("R4 read wm", {24'd0, rb}, 32'h3C);

      // R10: enable bits
      wr_reg(18'd0, 8'hFE);
      check("R10 vpar only", {30'd0, chk_en}, 32'd2);
      rd_reg(18'd0, rb);
      check("R10 upper read 0", {24'd0, rb}, 32'h02);

      // R2: long hold gives one ack
      cyc(1'b0, 18'd1, 8'h00, 6, 6'h0, rb, oe, n);
      check("R2 single ack", 32'(n), 32'd1);

      // R9: off-map writes, both ends
      cyc(1'b1, 18'd6, 8'h55, 3, 6'h0, rb, oe, n);
      check("R9 ack", 32'(n), 32'd1);
      cyc(1'b1, 18'h3FFFF, 8'h55, 3, 6'h0, rb, oe, n);
      check("R9 ack top", 32'(n), 32'd1);
      check("R9 wm unchanged", wm_levels, 32'h81FF3CA5);
      check("R9 chk unchanged", {30'd0, chk_en}, 32'd2);

      // R5: off-map read acknowledged, bus released
      cyc(1'b0, 18'd7, 8'h00, 3, 6'h0, rb, oe, n);
      check("R5 no drive", {31'd0, oe}, 32'd0);
      check("R5 ack", 32'(n), 32'd1);

      // R6: sticky errors
      @(posedge clk); #1 err_pulse = 6'h11;
      @(posedge clk); #1 err_pulse = 6'h00;
      repeat (4) @(posedge clk);
      rd_reg(18'd5, rb);
      check("R6 sticky", {24'd0, rb}, 32'h11);

      // R7: write 1 clears only selected bits
      wr_reg(18'd5, 8'hC1);
      rd_reg(18'd5, rb);
      check("R7 w1c", {24'd0, rb}, 32'h10);

      // R8: pulse beats clear on same edge
      cyc(1'b1, 18'd5, 8'h10, 3, 6'h30, rb, oe, n);
      rd_reg(18'd5, rb);
      check("R8 set wins", {24'd0, rb}, 32'h30);

      // R3/R4: write-read patterns on all watermarks
      for (int k = 0; k < 4; k++) begin
         wr_reg(18'(k + 1), 8'(8'h17 * (k + 3)));
         rd_reg(18'(k + 1), rb);
         check("R4 pattern", {24'd0, rb}, 32'(8'(8'h17 * (k + 3))));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule